// File: doc/BRIEF.md
# Issue Queue with Class-Timed Tag Wakeup

This block holds renamed instructions in an out-of-order core until both of their source operands are known to be available, then sends them on for operand read and execution without regard to program order. Every entry carries a destination physical tag, two source tags each with an availability flag, an operation class (ALU or memory) and an age stamp. The age stamp is a unique program-order number. A smaller age is older, and ages do not wrap while entries share the queue.

A dispatch group of up to four instructions is written into free entries in one cycle. The group is taken only when at least four entries are free. Each cycle a selector grants up to four eligible entries, oldest first. Issued instructions wake their consumers inside the queue. An ALU producer's tag is broadcast at the end of its issue cycle. A memory producer's tag is held back for one more cycle, which models the extra load-use latency. An external broadcast bus lets other producers wake entries. A flush input removes every entry younger than a given age.

Top module: `issue_queue`

## Requirements
- R1: An entry is not issued until both its source-ready flags are set. A flag is set either at dispatch or by a matching broadcast. An entry whose tag is never broadcast stays in the queue.
- R2: Eligibility alone decides issue. A younger eligible entry issues ahead of an older entry that is still waiting.
- R3: When an ALU-class entry (class bit 0) issues in cycle t, an entry waiting only on its destination tag issues in cycle t+1.
- R4: When a memory-class entry (class bit 1) issues in cycle t, an entry waiting only on its destination tag issues in cycle t+2.
- R5: When a tag is on an external wakeup lane (ext_wk_valid bit set) in cycle t, an entry waiting only on that tag issues in cycle t+1.
- R6: A tag broadcast in the same cycle that an entry is dispatched also sets that entry's matching source flag. This covers both the external lanes and an ALU issuing in that cycle.
- R7: At most four entries issue per cycle. Output slots fill from slot 0 with no gaps. Slot 0 holds the eligible entry with the smallest age, and ages rise with slot index. Eligible entries beyond the four oldest wait for a later cycle.
- R8: A dispatch group of up to four lanes (lane k used when disp_valid[k]) is accepted in one cycle. An accepted entry whose sources are ready issues in the next cycle.
- R9: disp_ready is low while fewer than four entries are free. Dispatch lanes driven while disp_ready is low are dropped.
- R10: In a flush cycle, every entry whose age is greater than flush_age is removed. No entry issues in that cycle, and disp_ready is low. Surviving eligible entries issue in the following cycle.
- R11: After reset the queue is empty, no issue slot is valid, and disp_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | DISP_W | Dispatch lane valid |
| disp_ready | output | 1 | Queue can take a full dispatch group |
| disp_dst | input | DISP_W*TAG_W | Destination physical tag per lane |
| disp_src1 | input | DISP_W*TAG_W | First source tag per lane |
| disp_src1_rdy | input | DISP_W | First source already available |
| disp_src2 | input | DISP_W*TAG_W | Second source tag per lane |
| disp_src2_rdy | input | DISP_W | Second source already available |
| disp_cls | input | DISP_W | Operation class: 0 ALU, 1 memory |
| disp_age | input | DISP_W*AGE_W | Program-order age per lane |
| ext_wk_valid | input | WK_W | External wakeup lane valid |
| ext_wk_tag | input | WK_W*TAG_W | External wakeup tag per lane |
| flush_valid | input | 1 | Flush request |
| flush_age | input | AGE_W | Entries with a greater age are removed |
| iss_valid | output | ISS_W | Issue slot valid |
| iss_dst | output | ISS_W*TAG_W | Issued destination tag |
| iss_src1 | output | ISS_W*TAG_W | Issued first source tag |
| iss_src2 | output | ISS_W*TAG_W | Issued second source tag |
| iss_cls | output | ISS_W | Issued operation class |
| iss_age | output | ISS_W*AGE_W | Issued age |

## Verification
A dependent chain of adds, loads and a store is replayed, with the cycle of every issue predicted by the scoreboard. This separates the one-cycle ALU wakeup from the two-cycle memory wakeup, and it shows that a younger independent store overtakes a stalled older add. A burst of six entries woken by one external tag has ages deliberately out of entry order, which shows that selection follows age and not storage position, and that the fifth and sixth wait a cycle. Further sequences check three things. Dispatch in the same cycle as a wakeup must catch the tag. A flush must remove exactly the younger entries while holding back an older ready one for one cycle. A full queue must reject a group of ready instructions, which would issue at once if any were taken.

// File: rtl/iq_pkg.sv
`timescale 1ns/1ps
package iq_pkg;

  typedef enum logic {
    CLS_ALU = 1'b0,
    CLS_MEM = 1'b1
  } iq_cls_e;

endpackage

// File: rtl/iq_alloc.sv
`timescale 1ns/1ps
// Maps dispatch lane k onto the k-th free entry and reports room for a full group.
module iq_alloc #(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 4,
  parameter int SLOT_W = (DISP_W > 1) ? $clog2(DISP_W) : 1
) (
  input  logic [DEPTH-1:0]             free,
  output logic [DEPTH-1:0]             take,
  output logic [DEPTH-1:0][SLOT_W-1:0] slot,
  output logic                         room
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(DISP_W);

  always_comb begin
    logic [CNT_W-1:0] cnt;
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      take[i] = free[i] && (cnt < LIM);
      slot[i] = cnt[SLOT_W-1:0];
      if (free[i]) cnt = cnt + CNT_W'(1);
    end
    room = (cnt >= LIM);
  end

endmodule

// File: rtl/iq_select.sv
`timescale 1ns/1ps
// Oldest-first selector: an entry's rank is the number of older eligible entries.
module iq_select #(
  parameter int DEPTH = 16,
  parameter int ISS_W = 4,
  parameter int AGE_W = 8
) (
  input  logic [DEPTH-1:0]              elig,
  input  logic [DEPTH-1:0][AGE_W-1:0]   age,
  output logic [ISS_W-1:0][DEPTH-1:0]   grant
);

  localparam int RANK_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][RANK_W-1:0] rank;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rank[i] = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && elig[j] && (age[j] < age[i])) rank[i] = rank[i] + RANK_W'(1);
      end
    end
  end

  always_comb begin
    for (int k = 0; k < ISS_W; k++) begin
      for (int i = 0; i < DEPTH; i++) begin
        grant[k][i] = elig[i] && (rank[i] == RANK_W'(k));
      end
    end
  end

endmodule

// File: rtl/iq_wakeup.sv
`timescale 1ns/1ps
// Builds the broadcast set: external lanes, ALU issues now, memory issues one cycle late.
module iq_wakeup
  import iq_pkg::*;
#(
  parameter int ISS_W = 4,
  parameter int WK_W  = 2,
  parameter int TAG_W = 6,
  parameter int NB    = WK_W + 2 * ISS_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [WK_W-1:0]               ext_vld,
  input  logic [WK_W-1:0][TAG_W-1:0]    ext_tag,
  input  logic [ISS_W-1:0]              iss_vld,
  input  logic [ISS_W-1:0][TAG_W-1:0]   iss_dst,
  input  logic [ISS_W-1:0]              iss_cls,
  output logic [NB-1:0]                 bc_vld,
  output logic [NB-1:0][TAG_W-1:0]      bc_tag
);

  logic [ISS_W-1:0]            alu_vld;
  logic [ISS_W-1:0]            ld_vld_d;
  logic [ISS_W-1:0]            ld_vld_q;
  logic [ISS_W-1:0][TAG_W-1:0] ld_tag_q;

  always_comb begin
    for (int k = 0; k < ISS_W; k++) begin
      alu_vld[k]  = iss_vld[k] && (iq_cls_e'(iss_cls[k]) == CLS_ALU);
      ld_vld_d[k] = iss_vld[k] && (iq_cls_e'(iss_cls[k]) == CLS_MEM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_vld_q <= '0;
      ld_tag_q <= '0;
    end else begin
      ld_vld_q <= ld_vld_d;
      for (int k = 0; k < ISS_W; k++) begin
        if (ld_vld_d[k]) ld_tag_q[k] <= iss_dst[k];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < WK_W; g++) begin : g_ext
      assign bc_vld[g] = ext_vld[g];
      assign bc_tag[g] = ext_tag[g];
    end
    for (g = 0; g < ISS_W; g++) begin : g_iss
      assign bc_vld[WK_W + g]         = alu_vld[g];
      assign bc_tag[WK_W + g]         = iss_dst[g];
      assign bc_vld[WK_W + ISS_W + g] = ld_vld_q[g];
      assign bc_tag[WK_W + ISS_W + g] = ld_tag_q[g];
    end
  endgenerate

endmodule

// File: rtl/issue_queue.sv
`timescale 1ns/1ps
module issue_queue
  import iq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 6,
  parameter int AGE_W  = 8,
  parameter int DISP_W = 4,
  parameter int ISS_W  = 4,
  parameter int WK_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DISP_W-1:0]             disp_valid,
  output logic                          disp_ready,
  input  logic [DISP_W-1:0][TAG_W-1:0]  disp_dst,
  input  logic [DISP_W-1:0][TAG_W-1:0]  disp_src1,
  input  logic [DISP_W-1:0]             disp_src1_rdy,
  input  logic [DISP_W-1:0][TAG_W-1:0]  disp_src2,
  input  logic [DISP_W-1:0]             disp_src2_rdy,
  input  logic [DISP_W-1:0]             disp_cls,
  input  logic [DISP_W-1:0][AGE_W-1:0]  disp_age,
  input  logic [WK_W-1:0]               ext_wk_valid,
  input  logic [WK_W-1:0][TAG_W-1:0]    ext_wk_tag,
  input  logic                          flush_valid,
  input  logic [AGE_W-1:0]              flush_age,
  output logic [ISS_W-1:0]              iss_valid,
  output logic [ISS_W-1:0][TAG_W-1:0]   iss_dst,
  output logic [ISS_W-1:0][TAG_W-1:0]   iss_src1,
  output logic [ISS_W-1:0][TAG_W-1:0]   iss_src2,
  output logic [ISS_W-1:0]              iss_cls,
  output logic [ISS_W-1:0][AGE_W-1:0]   iss_age
);

  localparam int NB     = WK_W + 2 * ISS_W;
  localparam int SLOT_W = (DISP_W > 1) ? $clog2(DISP_W) : 1;

  typedef struct packed {
    logic [TAG_W-1:0] dst;
    logic [TAG_W-1:0] s1;
    logic             s1r;
    logic [TAG_W-1:0] s2;
    logic             s2r;
    logic             cls;
    logic [AGE_W-1:0] age;
  } ent_t;

  ent_t [DEPTH-1:0]             ent_q, ent_n;
  logic [DEPTH-1:0]             vld_q, vld_n, ent_we;
  logic [DEPTH-1:0]             take, elig, issued;
  logic [DEPTH-1:0][SLOT_W-1:0] slot;
  logic [DEPTH-1:0][AGE_W-1:0]  ages;
  logic [ISS_W-1:0][DEPTH-1:0]  grant;
  logic                         room;
  logic [NB-1:0]                bc_vld;
  logic [NB-1:0][TAG_W-1:0]     bc_tag;

  function automatic logic tag_hit(input logic [TAG_W-1:0] t,
                                   input logic [NB-1:0] v,
                                   input logic [NB-1:0][TAG_W-1:0] tg);
    logic h;
    h = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (v[b] && (tg[b] == t)) h = 1'b1;
    end
    return h;
  endfunction

  iq_alloc #(.DEPTH(DEPTH), .DISP_W(DISP_W), .SLOT_W(SLOT_W)) u_alloc (
    .free (~vld_q),
    .take (take),
    .slot (slot),
    .room (room)
  );

  assign disp_ready = room && !flush_valid;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      elig[i] = vld_q[i] && ent_q[i].s1r && ent_q[i].s2r;
      ages[i] = ent_q[i].age;
    end
  end

  iq_select #(.DEPTH(DEPTH), .ISS_W(ISS_W), .AGE_W(AGE_W)) u_sel (
    .elig  (elig),
    .age   (ages),
    .grant (grant)
  );

  // Issue slot mux; nothing leaves during a flush cycle.
  always_comb begin
    iss_valid = '0;
    iss_dst   = '0;
    iss_src1  = '0;
    iss_src2  = '0;
    iss_cls   = '0;
    iss_age   = '0;
    for (int k = 0; k < ISS_W; k++) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (grant[k][i]) begin
          iss_valid[k] = !flush_valid;
          iss_dst[k]   = ent_q[i].dst;
          iss_src1[k]  = ent_q[i].s1;
          iss_src2[k]  = ent_q[i].s2;
          iss_cls[k]   = ent_q[i].cls;
          iss_age[k]   = ent_q[i].age;
        end
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      issued[i] = 1'b0;
      for (int k = 0; k < ISS_W; k++) issued[i] = issued[i] | grant[k][i];
      issued[i] = issued[i] && !flush_valid;
    end
  end

  iq_wakeup #(.ISS_W(ISS_W), .WK_W(WK_W), .TAG_W(TAG_W), .NB(NB)) u_wk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_vld (ext_wk_valid),
    .ext_tag (ext_wk_tag),
    .iss_vld (iss_valid),
    .iss_dst (iss_dst),
    .iss_cls (iss_cls),
    .bc_vld  (bc_vld),
    .bc_tag  (bc_tag)
  );

  // Next state of every entry.
  always_comb begin
    ent_n = ent_q;
    vld_n = vld_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i]) begin
        if (issued[i] || (flush_valid && (ent_q[i].age > flush_age))) begin
          vld_n[i] = 1'b0;
        end else begin
          ent_n[i].s1r = ent_q[i].s1r | tag_hit(ent_q[i].s1, bc_vld, bc_tag);
          ent_n[i].s2r = ent_q[i].s2r | tag_hit(ent_q[i].s2, bc_vld, bc_tag);
        end
      end else if (take[i] && disp_ready && disp_valid[slot[i]]) begin
        vld_n[i]     = 1'b1;
        ent_n[i].dst = disp_dst[slot[i]];
        ent_n[i].s1  = disp_src1[slot[i]];
        ent_n[i].s2  = disp_src2[slot[i]];
        ent_n[i].s1r = disp_src1_rdy[slot[i]] | tag_hit(disp_src1[slot[i]], bc_vld, bc_tag);
        ent_n[i].s2r = disp_src2_rdy[slot[i]] | tag_hit(disp_src2[slot[i]], bc_vld, bc_tag);
        ent_n[i].cls = disp_cls[slot[i]];
        ent_n[i].age = disp_age[slot[i]];
      end
    end
    ent_we = vld_q | vld_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ent_q <= '0;
    end else begin
      vld_q <= vld_n;
      for (int i = 0; i < DEPTH; i++) begin
        if (ent_we[i]) ent_q[i] <= ent_n[i];
      end
    end
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (iss_valid == '0 && disp_ready)); // R11

  AST_NO_FILL_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_ready |=> ($countones(vld_q) <= $past($countones(vld_q)))); // R9

  genvar g;
  generate
    for (g = 1; g < ISS_W; g++) begin : g_slot_chk
      AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[g] |-> iss_valid[g-1]); // R7
      AST_SLOT_AGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[g] |-> (iss_age[g-1] < iss_age[g])); // R7
    end
    for (g = 0; g < DEPTH; g++) begin : g_flush_chk
      AST_FLUSH_DROPS_YOUNG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush_valid) && vld_q[g]) |-> (ent_q[g].age <= $past(flush_age))); // R10
    end
  endgenerate

endmodule

// File: tb/tb_issue_queue.sv
`timescale 1ns/1ps
module tb_issue_queue;

  localparam int DEPTH  = 16;
  localparam int TAG_W  = 6;
  localparam int AGE_W  = 8;
  localparam int DISP_W = 4;
  localparam int ISS_W  = 4;
  localparam int WK_W   = 2;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic [DISP_W-1:0]             disp_valid;
  logic                          disp_ready;
  logic [DISP_W-1:0][TAG_W-1:0]  disp_dst, disp_src1, disp_src2;
  logic [DISP_W-1:0]             disp_src1_rdy, disp_src2_rdy, disp_cls;
  logic [DISP_W-1:0][AGE_W-1:0]  disp_age;
  logic [WK_W-1:0]               ext_wk_valid;
  logic [WK_W-1:0][TAG_W-1:0]    ext_wk_tag;
  logic                          flush_valid;
  logic [AGE_W-1:0]              flush_age;
  logic [ISS_W-1:0]              iss_valid;
  logic [ISS_W-1:0][TAG_W-1:0]   iss_dst, iss_src1, iss_src2;
  logic [ISS_W-1:0]              iss_cls;
  logic [ISS_W-1:0][AGE_W-1:0]   iss_age;

  issue_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .AGE_W(AGE_W), .DISP_W(DISP_W),
                .ISS_W(ISS_W), .WK_W(WK_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_dst(disp_dst), .disp_src1(disp_src1), .disp_src1_rdy(disp_src1_rdy),
    .disp_src2(disp_src2), .disp_src2_rdy(disp_src2_rdy),
    .disp_cls(disp_cls), .disp_age(disp_age),
    .ext_wk_valid(ext_wk_valid), .ext_wk_tag(ext_wk_tag),
    .flush_valid(flush_valid), .flush_age(flush_age),
    .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_src1(iss_src1),
    .iss_src2(iss_src2), .iss_cls(iss_cls), .iss_age(iss_age)
  );

  typedef struct {
    int    cyc;
    int    age;
    int    dst;
    string req;
  } exp_t;

  exp_t expq[$];
  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;
  bit   done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clr_in();
    disp_valid    = '0;
    disp_dst      = '0;
    disp_src1     = '0;
    disp_src2     = '0;
    disp_src1_rdy = '0;
    disp_src2_rdy = '0;
    disp_cls      = '0;
    disp_age      = '0;
    ext_wk_valid  = '0;
    ext_wk_tag    = '0;
    flush_valid   = 1'b0;
    flush_age     = '0;
  endtask

  task automatic put(input int k, input int dst, input int s1, input bit r1,
                     input int s2, input bit r2, input bit cls, input int age);
    disp_valid[k]    = 1'b1;
    disp_dst[k]      = TAG_W'(dst);
    disp_src1[k]     = TAG_W'(s1);
    disp_src1_rdy[k] = r1;
    disp_src2[k]     = TAG_W'(s2);
    disp_src2_rdy[k] = r2;
    disp_cls[k]      = cls;
    disp_age[k]      = AGE_W'(age);
  endtask

  task automatic want(input int c, input int age, input int dst, input string req);
    exp_t e;
    e.cyc = c;
    e.age = age;
    e.dst = dst;
    e.req = req;
    expq.push_back(e);
  endtask

  // Monitor: every issued slot is popped against the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < ISS_W; k++) begin
        if (iss_valid[k]) begin
          if (expq.size() == 0) begin
            checks++;
            fails++;
            $display("FAIL R1 unexpected issue actual=age%0d expected=none", iss_age[k]);
          end else begin
            exp_t e;
            e = expq.pop_front();
            chk(cyc == e.cyc, e.req, "issue cycle", cyc, e.cyc);
            chk(int'(iss_age[k]) == e.age, e.req, "issue age", int'(iss_age[k]), e.age);
            chk(int'(iss_dst[k]) == e.dst, e.req, "issue dst", int'(iss_dst[k]), e.dst);
          end
        end
      end
    end
  end

  localparam bit ALU = 1'b0;
  localparam bit MEM = 1'b1;

  initial begin
    int d;
    rst_n = 1'b0;
    clr_in();
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    chk(iss_valid == '0, "R11", "iss_valid after reset", int'(iss_valid), 0);
    chk(disp_ready == 1'b1, "R11", "disp_ready after reset", int'(disp_ready), 1);

    // Dependent add/load chain.
    tick();
    d = cyc;
    put(0, 33, 2, 1, 3, 1, ALU, 0);
    put(1, 34, 33, 0, 0, 1, MEM, 1);
    put(2, 35, 34, 0, 0, 1, ALU, 2);
    put(3, 63, 33, 0, 3, 1, MEM, 3);
    want(d + 1, 0, 33, "R8");
    want(d + 2, 1, 34, "R3");
    want(d + 2, 3, 63, "R2");
    want(d + 2, 4, 36, "R6");
    want(d + 4, 2, 35, "R4");
    want(d + 5, 5, 1,  "R3");
    want(d + 7, 6, 2,  "R4");
    tick();
    clr_in();
    put(0, 36, 33, 0, 5, 1, ALU, 4);
    put(1, 1, 35, 0, 0, 1, MEM, 5);
    put(2, 2, 1, 0, 35, 0, ALU, 6);
    tick();
    clr_in();
    repeat (10) tick();

    // Six entries woken together, ages out of storage order.
    put(0, 20, 40, 0, 1, 1, ALU, 20);
    put(1, 21, 40, 0, 1, 1, ALU, 21);
    put(2, 22, 40, 0, 1, 1, ALU, 22);
    put(3, 23, 40, 0, 1, 1, ALU, 23);
    tick();
    clr_in();
    put(0, 10, 40, 0, 1, 1, ALU, 10);
    put(1, 11, 40, 0, 1, 1, ALU, 11);
    tick();
    clr_in();
    tick();
    d = cyc;
    ext_wk_valid[0] = 1'b1;
    ext_wk_tag[0]   = TAG_W'(40);
    want(d + 1, 10, 10, "R5");
    want(d + 1, 11, 11, "R7");
    want(d + 1, 20, 20, "R7");
    want(d + 1, 21, 21, "R7");
    want(d + 2, 22, 22, "R7");
    want(d + 2, 23, 23, "R7");
    tick();
    clr_in();
    repeat (8) tick();

    // Wakeup in the dispatch cycle; one entry left waiting.
    d = cyc;
    put(0, 30, 41, 0, 1, 1, ALU, 30);
    put(1, 31, 42, 0, 1, 1, ALU, 45);
    ext_wk_valid[0] = 1'b1;
    ext_wk_tag[0]   = TAG_W'(41);
    want(d + 1, 30, 30, "R6");
    tick();
    clr_in();
    repeat (3) tick();

    // Flush of younger entries, ready older entry held one cycle.
    d = cyc;
    put(0, 12, 1, 1, 1, 1, ALU, 39);
    put(1, 13, 50, 0, 1, 1, ALU, 40);
    put(2, 14, 50, 0, 1, 1, ALU, 42);
    put(3, 15, 50, 0, 1, 1, ALU, 43);
    tick();
    clr_in();
    flush_valid = 1'b1;
    flush_age   = AGE_W'(41);
    put(0, 16, 1, 1, 1, 1, ALU, 60);
    #1;
    chk(disp_ready == 1'b0, "R10", "disp_ready in flush", int'(disp_ready), 0);
    want(d + 2, 39, 12, "R10");
    want(d + 3, 40, 13, "R10");
    tick();
    clr_in();
    ext_wk_valid  = 2'b11;
    ext_wk_tag[0] = TAG_W'(50);
    ext_wk_tag[1] = TAG_W'(42);
    tick();
    clr_in();
    repeat (5) tick();

    // Fill the queue, then offer ready work that must be dropped.
    for (int g = 0; g < 4; g++) begin
      for (int k = 0; k < 4; k++) put(k, 20 + k, 55, 0, 1, 1, ALU, 100 + 4 * g + k);
      tick();
      clr_in();
    end
    #1;
    chk(disp_ready == 1'b0, "R9", "disp_ready when full", int'(disp_ready), 0);
    for (int k = 0; k < 4; k++) put(k, 1 + k, 1, 1, 1, 1, ALU, 1 + k);
    tick();
    clr_in();
    flush_valid = 1'b1;
    flush_age   = AGE_W'(99);
    tick();
    clr_in();
    #1;
    chk(disp_ready == 1'b1, "R9", "disp_ready after clear", int'(disp_ready), 1);
    ext_wk_valid[0] = 1'b1;
    ext_wk_tag[0]   = TAG_W'(55);
    tick();
    clr_in();
    repeat (6) tick();

    chk(expq.size() == 0, "R1", "pending expected issues", expq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule